// File: doc/BRIEF.md
# Direction-Tracking I2C Bus Multiplexer

This block joins one upstream I2C controller bus to a parameterised number of downstream target buses. Each downstream port has its own enable. Only enabled ports receive the forwarded clock and data, and only enabled ports are listened to.

The block never wires two open-drain nets together. Instead it samples every line through a synchroniser on a fast system clock and follows the protocol: START, address byte, read/write bit, data bytes and acknowledge slots. From this it decides, bit by bit, which side owns SDA, and it copies a low level only from the owner to the other side. The two sides therefore never hold each other low.

SCL always flows from the controller to the enabled targets. The block only ever pulls a line low or lets it go. Two outputs report whether a transaction is open and which side is currently driving data.

Top module: `i2cmx_top`

## Requirements
- R1: Reset clears the busy output and the direction output, and releases every pull output.
- R2: SDA falling while SCL is high on the controller side sets busy. SDA rising while SCL is high clears busy and sets direction to 0.
- R3: Each enabled port's SCL pull is active exactly while the synchronised controller SCL is low. Controller SCL is never pulled.
- R4: A port whose enable is 0 never has its SCL or SDA pulled, and a low level on its SDA does not reach the controller.
- R5: During the address byte and during bytes written toward the targets, direction is 0. Each enabled target's SDA then carries the controller's SDA level.
- R6: The acknowledge slot after the address byte, and after each written byte, is owned by the target. Direction is 1 and the target's level appears on controller SDA.
- R7: When the read/write bit (bit 0 of the address byte, the last one sent) is 1 and the address is acknowledged, data bytes are owned by the target (direction 1). The acknowledge slot after each such byte is owned by the controller (direction 0).
- R8: After a controller NACK (SDA high in its acknowledge slot), the next bit stays with the controller, so a STOP is recognised.
- R9: A START while busy (repeated START) keeps busy at 1, restarts the bit count and takes a fresh address byte with a new read/write bit.
- R10: Controller SDA and target SDA are never pulled in the same cycle.
- R11: Direction changes only right after a synchronised SCL falling edge, and it has its new value before the next data change, a quarter SCL period after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_scl_in | input | 1 | Level of the controller-side SCL net |
| ctl_sda_in | input | 1 | Level of the controller-side SDA net |
| ctl_sda_pull | output | 1 | 1 pulls controller SDA low |
| port_en | input | NPORTS | Per-port enable |
| tgt_sda_in | input | NPORTS | Levels of the target-side SDA nets |
| tgt_scl_pull | output | NPORTS | 1 pulls that port's SCL low |
| tgt_sda_pull | output | NPORTS | 1 pulls that port's SDA low |
| busy | output | 1 | High from START to STOP |
| dir | output | 1 | 0: controller drives data, 1: a target drives data |

## Verification
A level change on any net reaches the pull outputs on the opposite side two system clocks later, through the synchroniser. Busy and direction update on the third clock after the SCL or SDA edge that causes them. The bench moves the bus in quarter-period steps of five clocks. It checks the clock forwarding and the new direction at the end of the first low quarter, after the switch and before any data change. It checks the data, busy and exclusivity at the end of the high quarter, well after both latencies have elapsed. START and STOP effects are checked one full quarter after the SDA edge.

// File: rtl/i2cmx_pkg.sv
package i2cmx_pkg;
   typedef enum logic {
      SRC_CTL = 1'b0,
      SRC_TGT = 1'b1
   } src_e;

   localparam int CNT_W     = 4;
   localparam int LAST_DATA = 7;
   localparam int ACK_SLOT  = 8;
endpackage

// File: rtl/i2cmx_sync.sv
module i2cmx_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '1;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cmx_tracker.sv
module i2cmx_tracker
   import i2cmx_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic scl,
   input  logic sda_ctl,
   input  logic sda_tgt,
   output logic busy,
   output src_e src,
   output logic fall_evt
);
   logic             scl_q, sda_q;
   logic [CNT_W-1:0] cnt;
   logic             first_byte, seen_rise, rw, ack_low;
   logic             rise_evt, start_evt, stop_evt, bit_val;

   assign rise_evt  = ~scl_q & scl;
   assign fall_evt  = scl_q & ~scl;
   assign start_evt = scl & scl_q & sda_q & ~sda_ctl & (src == SRC_CTL);
   assign stop_evt  = scl & scl_q & ~sda_q & sda_ctl & (src == SRC_CTL);
   assign bit_val   = (src == SRC_TGT) ? sda_tgt : sda_ctl;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q      <= 1'b1;
         sda_q      <= 1'b1;
         cnt        <= '0;
         first_byte <= 1'b0;
         seen_rise  <= 1'b0;
         rw         <= 1'b0;
         ack_low    <= 1'b0;
         busy       <= 1'b0;
         src        <= SRC_CTL;
      end else begin
         scl_q <= scl;
         sda_q <= sda_ctl;
         if (start_evt) begin
            busy       <= 1'b1;
            cnt        <= '0;
            first_byte <= 1'b1;
            seen_rise  <= 1'b0;
            rw         <= 1'b0;
            src        <= SRC_CTL;
         end else if (stop_evt) begin
            busy       <= 1'b0;
            cnt        <= '0;
            first_byte <= 1'b0;
            seen_rise  <= 1'b0;
            src        <= SRC_CTL;
         end else if (busy) begin
            if (rise_evt) begin
               seen_rise <= 1'b1;
               if (first_byte && cnt == CNT_W'(LAST_DATA)) rw <= bit_val;
               if (cnt == CNT_W'(ACK_SLOT)) ack_low <= ~bit_val;
            end else if (fall_evt && seen_rise) begin
               seen_rise <= 1'b0;
               if (cnt == CNT_W'(LAST_DATA)) begin
                  cnt <= CNT_W'(ACK_SLOT);
                  // acknowledge comes from the side that did not send the byte
                  src <= (first_byte || !rw) ? SRC_TGT : SRC_CTL;
               end else if (cnt == CNT_W'(ACK_SLOT)) begin
                  cnt        <= '0;
                  first_byte <= 1'b0;
                  src        <= (rw && ack_low) ? SRC_TGT : SRC_CTL;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2cmx_top.sv
module i2cmx_top
   import i2cmx_pkg::*;
#(
   parameter int NPORTS      = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_scl_in,
   input  logic              ctl_sda_in,
   output logic              ctl_sda_pull,
   input  logic [NPORTS-1:0] port_en,
   input  logic [NPORTS-1:0] tgt_sda_in,
   output logic [NPORTS-1:0] tgt_scl_pull,
   output logic [NPORTS-1:0] tgt_sda_pull,
   output logic              busy,
   output logic              dir
);
   localparam int SW = NPORTS + 2;

   if (NPORTS < 1 || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("i2cmx_top: NPORTS must be >= 1 and SYNC_STAGES >= 2");
   end

   logic [SW-1:0]     sync_q;
   logic              scl_s, sda_c_s, sda_t_all;
   logic [NPORTS-1:0] sda_t_s;
   src_e              src;
   logic              trk_fall;
   logic              ctl_pull_d;
   logic [NPORTS-1:0] scl_pull_d, sda_pull_d;

   i2cmx_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({tgt_sda_in, ctl_sda_in, ctl_scl_in}),
      .q   (sync_q)
   );

   assign scl_s     = sync_q[0];
   assign sda_c_s   = sync_q[1];
   assign sda_t_s   = sync_q[SW-1:2];
   assign sda_t_all = &(sda_t_s | ~port_en);

   i2cmx_tracker u_trk (
      .clk      (clk),
      .rst      (rst),
      .scl      (scl_s),
      .sda_ctl  (sda_c_s),
      .sda_tgt  (sda_t_all),
      .busy     (busy),
      .src      (src),
      .fall_evt (trk_fall)
   );

   assign dir        = (src == SRC_TGT);
   assign ctl_pull_d = (src == SRC_TGT) & ~sda_t_all;

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      assign scl_pull_d[i] = port_en[i] & ~scl_s;
      assign sda_pull_d[i] = port_en[i] & (src == SRC_CTL) & ~sda_c_s;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            ctl_sda_pull <= 1'b0;
            tgt_scl_pull <= '0;
            tgt_sda_pull <= '0;
         end else begin
            ctl_sda_pull <= ctl_pull_d;
            tgt_scl_pull <= scl_pull_d;
            tgt_sda_pull <= sda_pull_d;
         end
      end
   end else begin : g_out_comb
      assign ctl_sda_pull = ctl_pull_d;
      assign tgt_scl_pull = scl_pull_d;
      assign tgt_sda_pull = sda_pull_d;
   end
endmodule

// File: rtl/i2cmx_chk.sv
module i2cmx_chk #(
   parameter int NPORTS = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              busy,
   input logic              dir,
   input logic              ctl_sda_pull,
   input logic [NPORTS-1:0] tgt_scl_pull,
   input logic [NPORTS-1:0] tgt_sda_pull,
   input logic [NPORTS-1:0] port_en,
   input logic              fall_evt
);
   // R10: the two sides of SDA are never pulled together
   a_r10_one_way: assert property (@(posedge clk) disable iff (rst)
      !(ctl_sda_pull && (|tgt_sda_pull)));

   // R4: a disabled port stays released
   a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
      ((tgt_scl_pull | tgt_sda_pull) & ~port_en) == '0);

   // R11: direction moves only after an SCL falling edge
   a_r11_dir_on_fall: assert property (@(posedge clk) disable iff (rst)
      (dir != $past(dir)) |-> $past(fall_evt));

   // R2: with no transaction open the controller owns SDA
   a_r2_idle_dir: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !dir);

   // R2: the transaction flag only rises while the controller owns SDA
   a_r2_busy_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !dir);
endmodule

bind i2cmx_top i2cmx_chk #(.NPORTS(NPORTS)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .busy         (busy),
   .dir          (dir),
   .ctl_sda_pull (ctl_sda_pull),
   .tgt_scl_pull (tgt_scl_pull),
   .tgt_sda_pull (tgt_sda_pull),
   .port_en      (port_en),
   .fall_evt     (trk_fall)
);

// File: tb/test_i2cmx_top.sv
module test_i2cmx_top;
   localparam int NP = 2;
   localparam int Q  = 5;
   // vector: [10] byte driver (1 target), [9:2] byte, [1] ack driver, [0] ack level
   localparam logic [10:0] VEC [6] = '{
      {1'b0, 8'h3D, 1'b1, 1'b0},
      {1'b1, 8'hA5, 1'b0, 1'b0},
      {1'b1, 8'h5A, 1'b0, 1'b1},
      {1'b0, 8'h3C, 1'b1, 1'b0},
      {1'b0, 8'hC3, 1'b1, 1'b0},
      {1'b0, 8'h96, 1'b1, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic [NP-1:0] s_sda_low = '0;
   logic [NP-1:0] port_en = 2'b01;
   logic          ctl_scl, ctl_sda, ctl_sda_pull, busy, dir;
   logic [NP-1:0] tgt_sda, tgt_scl, tgt_scl_pull, tgt_sda_pull;
   int            checks = 0, failures = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   // pull-up nets: low when any party pulls
   assign ctl_scl = ~m_scl_low;
   assign ctl_sda = ~(m_sda_low | ctl_sda_pull);
   assign tgt_sda = ~(s_sda_low | tgt_sda_pull);
   assign tgt_scl = ~tgt_scl_pull;

   i2cmx_top #(.NPORTS(NP)) i_i2cmx_top (
      .clk          (clk),
      .rst          (rst),
      .ctl_scl_in   (ctl_scl),
      .ctl_sda_in   (ctl_sda),
      .ctl_sda_pull (ctl_sda_pull),
      .port_en      (port_en),
      .tgt_sda_in   (tgt_sda),
      .tgt_scl_pull (tgt_scl_pull),
      .tgt_sda_pull (tgt_sda_pull),
      .busy         (busy),
      .dir          (dir)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic send_bit(input bit drv, input bit b, input string tag);
      q(); m_scl_low = 1'b1; q();
      chk(tgt_scl_pull == 2'b01, "R3", 32'(tgt_scl_pull), 32'h1);
      chk(dir == drv, "R11", 32'(dir), 32'(drv));
      if (!drv) begin
         m_sda_low = ~b; s_sda_low = '0;
      end else begin
         m_sda_low = 1'b0; s_sda_low = {1'b1, ~b};
      end
      q(); m_scl_low = 1'b0; q();
      chk(dir == drv, tag, 32'(dir), 32'(drv));
      chk(busy == 1'b1, tag, 32'(busy), 32'h1);
      chk(ctl_sda == b, tag, 32'(ctl_sda), 32'(b));
      chk(tgt_sda[0] == b, tag, 32'(tgt_sda[0]), 32'(b));
      chk(tgt_scl_pull == 2'b00, "R3", 32'(tgt_scl_pull), 32'h0);
      chk(tgt_sda_pull[1] == 1'b0, "R4", 32'(tgt_sda_pull[1]), 32'h0);
      chk(!(ctl_sda_pull && (|tgt_sda_pull)), "R10", 32'({ctl_sda_pull, tgt_sda_pull}), 32'h0);
   endtask

   task automatic send_byte(input logic [10:0] v, input string ovr);
      string tag;
      for (int i = 7; i >= 0; i--) begin
         tag = (ovr != "") ? ovr : (v[10] ? "R7" : "R5");
         send_bit(v[10], v[2+i], tag);
      end
      tag = (ovr != "") ? ovr : (v[1] ? "R6" : (v[0] ? "R8" : "R7"));
      send_bit(v[1], v[0], tag);
   endtask

   task automatic do_start(input string tag);
      m_sda_low = 1'b1; q();
      chk(busy == 1'b1, tag, 32'(busy), 32'h1);
      chk(dir == 1'b0, tag, 32'(dir), 32'h0);
   endtask

   task automatic do_stop();
      q(); m_scl_low = 1'b1; q();
      m_sda_low = 1'b1; s_sda_low = '0;
      q(); m_scl_low = 1'b0; q();
      m_sda_low = 1'b0; q();
      chk(busy == 1'b0, "R2", 32'(busy), 32'h0);
      chk(dir == 1'b0, "R2", 32'(dir), 32'h0);
      chk(ctl_sda_pull == 1'b0 && tgt_sda_pull == '0, "R2",
          32'({ctl_sda_pull, tgt_sda_pull}), 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b0 && dir == 1'b0, "R1", 32'({busy, dir}), 32'h0);
      chk(ctl_sda_pull == 1'b0 && tgt_scl_pull == '0 && tgt_sda_pull == '0, "R1",
          32'({ctl_sda_pull, tgt_scl_pull, tgt_sda_pull}), 32'h0);
      rst = 1'b0;
      repeat (6) @(negedge clk);
      chk(busy == 1'b0, "R2", 32'(busy), 32'h0);

      // table: a two-byte read ending in controller NACK, then a two-byte write ending in target NACK
      for (int k = 0; k < 6; k++) begin
         if (k % 3 == 0) do_start("R2");
         send_byte(VEC[k], "");
         if (k % 3 == 2) do_stop();
      end

      // repeated START: write address, then a read without STOP in between
      do_start("R2");
      send_byte({1'b0, 8'h3C, 1'b1, 1'b0}, "");
      q(); m_scl_low = 1'b1; q();
      m_sda_low = 1'b0; s_sda_low = '0;
      q(); m_scl_low = 1'b0; q();
      chk(busy == 1'b1, "R9", 32'(busy), 32'h1);
      do_start("R9");
      send_byte({1'b0, 8'h3D, 1'b1, 1'b0}, "R9");
      send_byte({1'b1, 8'h69, 1'b0, 1'b1}, "R9");
      do_stop();

      // reset in the middle of an address byte
      do_start("R2");
      send_bit(1'b0, 1'b0, "R5");
      send_bit(1'b0, 1'b1, "R5");
      q(); m_scl_low = 1'b1; m_sda_low = 1'b1; q();
      chk(tgt_scl_pull == 2'b01 && tgt_sda_pull == 2'b01, "R3",
          32'({tgt_scl_pull, tgt_sda_pull}), 32'h5);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0 && dir == 1'b0, "R1", 32'({busy, dir}), 32'h0);
      chk(ctl_sda_pull == 1'b0 && tgt_scl_pull == '0 && tgt_sda_pull == '0, "R1",
          32'({ctl_sda_pull, tgt_scl_pull, tgt_sda_pull}), 32'h0);
      m_scl_low = 1'b0; m_sda_low = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (6) @(negedge clk);
      chk(busy == 1'b0, "R1", 32'(busy), 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule